// File: doc/BRIEF.md
# Multi-Format Alpha Blend Datapath

This block composites a foreground picture over a background picture, one bus word at a time. Each accepted step takes a word of foreground pixels, a word of background pixels and one alpha byte per pixel. For every colour channel it forms `(fg*a + bg*(255-a)) >> 8` and packs the results into an output word. The foreground, the background and the result each carry their own 3-bit colour-format code. These codes pick one of six 16-bit or 32-bit channel orderings, and the three sides may differ. Components are converted between 5/6-bit and 8-bit widths by MSB alignment.

The block also works out how many pixels one word holds and how many bytes the surrounding byte FIFOs must pop or push for that word. A pixel-count input shortens the final word of a picture. Input and output use a valid/ready handshake with a single registered output stage. Stream framing, the FIFOs and sequencing are not part of this block.

Top module: `alpha_blend_dp`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_word` is all zeros until the first word is accepted.
- R2: `pix_per_word` equals BUS_BYTES/2 when all three format codes are 16-bit (codes 0 and 1), and BUS_BYTES/4 otherwise.
- R3: With `act` = min(`pix_avail`, `pix_per_word`), the sizes are encoded as byte count minus one: `fg_pop_m1` = act*fg width - 1, `bg_pop_m1` = act*bg width - 1, `alpha_pop_m1` = act - 1 and `res_push_m1` = act*result width - 1. The width is 2 bytes for codes 0 and 1 and 4 bytes otherwise.
- R4: The format codes have these layouts, MSB first. Code 0 is R5 G6 B5 and code 1 is B5 G6 R5. Code 2 is R G B A, code 3 is B G R A, code 4 is A R G B and code 5 is A B G R, each with 8-bit fields on byte boundaries.
- R5: A 5-bit or 6-bit component is widened by appending zeros below it, and an 8-bit component is narrowed by dropping its low bits. For example, with alpha 255, foreground 0x8B4513FF in code 2 gives 0x8A22 in a code 0 result.
- R6: Each result channel equals `(fg*a + bg*(255-a)) >> 8`, where pixel i uses alpha byte i (`alpha_word[8i+7:8i]`). Any alpha field in the background has no effect.
- R7: In a 32-bit result format the alpha field is always 0xFF.
- R8: In a 16-bit format pixel i occupies bits [16i+15:16i], and in a 32-bit format it occupies bits [32i+31:32i]. This applies on the inputs and on the output.
- R9: Pixels with index at or above `act`, and all bytes not covered by the active result pixels, are zero in `out_word`.
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high. A word accepted on one edge appears with `out_valid` high after that edge. It is held unchanged while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| fg_word | input | 8*BUS_BYTES | Foreground pixels |
| bg_word | input | 8*BUS_BYTES | Background pixels |
| alpha_word | input | 4*BUS_BYTES | One alpha byte per pixel slot |
| fg_fmt | input | 3 | Foreground format code |
| bg_fmt | input | 3 | Background format code |
| res_fmt | input | 3 | Result format code |
| pix_avail | input | $clog2(BUS_BYTES/2+1) | Pixels left in the picture (at least 1) |
| pix_per_word | output | $clog2(BUS_BYTES/2+1) | Pixels a word carries for these formats |
| fg_pop_m1 | output | $clog2(BUS_BYTES) | Foreground bytes to pop, minus one |
| bg_pop_m1 | output | $clog2(BUS_BYTES) | Background bytes to pop, minus one |
| alpha_pop_m1 | output | $clog2(BUS_BYTES/2) | Alpha bytes to pop, minus one |
| res_push_m1 | output | $clog2(BUS_BYTES) | Result bytes to push, minus one |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 8*BUS_BYTES | Blended result pixels |

## Verification
Every combination of the six foreground, six background and six result codes is driven. Each combination is run with alpha 0, alpha 255 and random alpha. Alpha 0 and 255 isolate the background and foreground paths, which exposes swapped channel orderings and wrong width conversion on a single side. Random alpha with random pixel data checks the weighted sum and the alpha-to-pixel pairing. In all-16-bit modes a word with one pixel available checks lane zeroing and the shortened sizes, while random output stalls exercise the hold behaviour of the output register.

// File: rtl/ab_pkg.sv
package ab_pkg;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } px_t;

   function automatic logic is16(input logic [2:0] f);
      return f[2:1] == 2'b00;
   endfunction

   function automatic px_t decode16(input logic [2:0] f, input logic [15:0] h);
      px_t p;
      p.g = {h[10:5], 2'b00};
      if (f == 3'd1) begin
         p.b = {h[15:11], 3'b000};
         p.r = {h[4:0], 3'b000};
      end else begin
         p.r = {h[15:11], 3'b000};
         p.b = {h[4:0], 3'b000};
      end
      return p;
   endfunction

   function automatic px_t decode32(input logic [2:0] f, input logic [31:0] w);
      px_t p;
      case (f)
         3'd3:    begin p.b = w[31:24]; p.g = w[23:16]; p.r = w[15:8]; end
         3'd4:    begin p.r = w[23:16]; p.g = w[15:8];  p.b = w[7:0];  end
         3'd5:    begin p.b = w[23:16]; p.g = w[15:8];  p.r = w[7:0];  end
         default: begin p.r = w[31:24]; p.g = w[23:16]; p.b = w[15:8]; end
      endcase
      return p;
   endfunction

   function automatic logic [15:0] encode16(input logic [2:0] f, input px_t p);
      if (f == 3'd1) return {p.b[7:3], p.g[7:2], p.r[7:3]};
      return {p.r[7:3], p.g[7:2], p.b[7:3]};
   endfunction

   function automatic logic [31:0] encode32(input logic [2:0] f, input px_t p);
      case (f)
         3'd3:    return {p.b, p.g, p.r, 8'hFF};
         3'd4:    return {8'hFF, p.r, p.g, p.b};
         3'd5:    return {8'hFF, p.b, p.g, p.r};
         default: return {p.r, p.g, p.b, 8'hFF};
      endcase
   endfunction

   function automatic logic [7:0] mix(input logic [7:0] f, input logic [7:0] b,
                                      input logic [7:0] a);
      logic [15:0] s;
      s = {8'd0, f} * {8'd0, a} + {8'd0, b} * {8'd0, 8'd255 - a};
      return s[15:8];
   endfunction

endpackage

// File: rtl/ab_size_calc.sv
module ab_size_calc
   import ab_pkg::*;
#(
   parameter int BUS_BYTES = 4,
   localparam int LANES = BUS_BYTES / 2,
   localparam int HALF  = BUS_BYTES / 4,
   localparam int CW    = $clog2(LANES + 1),
   localparam int SZW   = $clog2(BUS_BYTES),
   localparam int ALW   = $clog2(LANES)
) (
   input  logic [2:0]     fg_fmt,
   input  logic [2:0]     bg_fmt,
   input  logic [2:0]     res_fmt,
   input  logic [CW-1:0]  pix_avail,
   output logic [CW-1:0]  pix_per_word,
   output logic [CW-1:0]  act,
   output logic [SZW-1:0] fg_pop_m1,
   output logic [SZW-1:0] bg_pop_m1,
   output logic [ALW-1:0] alpha_pop_m1,
   output logic [SZW-1:0] res_push_m1
);
   int ppw_i, act_i, fgw, bgw, rsw;

   always_comb begin
      fgw   = is16(fg_fmt)  ? 2 : 4;
      bgw   = is16(bg_fmt)  ? 2 : 4;
      rsw   = is16(res_fmt) ? 2 : 4;
      ppw_i = (is16(fg_fmt) && is16(bg_fmt) && is16(res_fmt)) ? LANES : HALF;
      act_i = (int'(pix_avail) > ppw_i) ? ppw_i : int'(pix_avail);
   end

   assign pix_per_word = CW'(ppw_i);
   assign act          = CW'(act_i);
   assign fg_pop_m1    = SZW'(act_i * fgw - 1);
   assign bg_pop_m1    = SZW'(act_i * bgw - 1);
   assign alpha_pop_m1 = ALW'(act_i - 1);
   assign res_push_m1  = SZW'(act_i * rsw - 1);
endmodule

// File: rtl/ab_lane.sv
module ab_lane
   import ab_pkg::*;
(
   input  logic        en,
   input  logic [2:0]  fg_fmt,
   input  logic [2:0]  bg_fmt,
   input  logic [2:0]  res_fmt,
   input  logic [15:0] fg16,
   input  logic [31:0] fg32,
   input  logic [15:0] bg16,
   input  logic [31:0] bg32,
   input  logic [7:0]  alpha,
   output logic [15:0] res16,
   output logic [31:0] res32
);
   logic [15:0] f16, b16;
   logic [31:0] f32, b32;
   logic [7:0]  a;
   px_t fp, bp, rp;

   // idle lanes see zero inputs, so no stale pixel reaches the adders
   assign f16 = en ? fg16  : '0;
   assign f32 = en ? fg32  : '0;
   assign b16 = en ? bg16  : '0;
   assign b32 = en ? bg32  : '0;
   assign a   = en ? alpha : '0;

   always_comb begin
      fp   = is16(fg_fmt) ? decode16(fg_fmt, f16) : decode32(fg_fmt, f32);
      bp   = is16(bg_fmt) ? decode16(bg_fmt, b16) : decode32(bg_fmt, b32);
      rp.r = mix(fp.r, bp.r, a);
      rp.g = mix(fp.g, bp.g, a);
      rp.b = mix(fp.b, bp.b, a);
   end

   assign res16 = en ? encode16(res_fmt, rp) : '0;
   assign res32 = en ? encode32(res_fmt, rp) : '0;
endmodule

// File: rtl/ab_out_reg.sv
module ab_out_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end
endmodule

// File: rtl/alpha_blend_dp.sv
module alpha_blend_dp
   import ab_pkg::*;
#(
   parameter int BUS_BYTES = 4,
   localparam int LANES = BUS_BYTES / 2,
   localparam int HALF  = BUS_BYTES / 4,
   localparam int BW    = 8 * BUS_BYTES,
   localparam int AW    = 8 * LANES,
   localparam int CW    = $clog2(LANES + 1),
   localparam int SZW   = $clog2(BUS_BYTES),
   localparam int ALW   = $clog2(LANES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [BW-1:0]  fg_word,
   input  logic [BW-1:0]  bg_word,
   input  logic [AW-1:0]  alpha_word,
   input  logic [2:0]     fg_fmt,
   input  logic [2:0]     bg_fmt,
   input  logic [2:0]     res_fmt,
   input  logic [CW-1:0]  pix_avail,
   output logic [CW-1:0]  pix_per_word,
   output logic [SZW-1:0] fg_pop_m1,
   output logic [SZW-1:0] bg_pop_m1,
   output logic [ALW-1:0] alpha_pop_m1,
   output logic [SZW-1:0] res_push_m1,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [BW-1:0]  out_word
);
   if (BUS_BYTES < 4 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("alpha_blend_dp: BUS_BYTES must be a power of two, at least 4");
   end

   logic [CW-1:0] act;
   logic [BW-1:0] word16, word32, word_c;

   ab_size_calc #(.BUS_BYTES(BUS_BYTES)) u_size (
      .fg_fmt       (fg_fmt),
      .bg_fmt       (bg_fmt),
      .res_fmt      (res_fmt),
      .pix_avail    (pix_avail),
      .pix_per_word (pix_per_word),
      .act          (act),
      .fg_pop_m1    (fg_pop_m1),
      .bg_pop_m1    (bg_pop_m1),
      .alpha_pop_m1 (alpha_pop_m1),
      .res_push_m1  (res_push_m1)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [31:0] fg32, bg32, res32;
      logic [15:0] res16;
      if (i < HALF) begin : g_wide
         assign fg32 = fg_word[32*i +: 32];
         assign bg32 = bg_word[32*i +: 32];
         assign word32[32*i +: 32] = res32;
      end else begin : g_narrow
         assign fg32 = '0;
         assign bg32 = '0;
      end

      ab_lane u_lane (
         .en      (i < int'(act)),
         .fg_fmt  (fg_fmt),
         .bg_fmt  (bg_fmt),
         .res_fmt (res_fmt),
         .fg16    (fg_word[16*i +: 16]),
         .fg32    (fg32),
         .bg16    (bg_word[16*i +: 16]),
         .bg32    (bg32),
         .alpha   (alpha_word[8*i +: 8]),
         .res16   (res16),
         .res32   (res32)
      );

      assign word16[16*i +: 16] = res16;
   end

   assign word_c = is16(res_fmt) ? word16 : word32;

   ab_out_reg #(.W(BW)) u_oreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (word_c),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_word)
   );
endmodule

// File: rtl/ab_chk.sv
module ab_chk #(
   parameter int BUS_BYTES = 4,
   localparam int LANES = BUS_BYTES / 2,
   localparam int BW    = 8 * BUS_BYTES,
   localparam int CW    = $clog2(LANES + 1),
   localparam int ALW   = $clog2(LANES)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_ready,
   input logic [2:0]     res_fmt,
   input logic [CW-1:0]  pix_avail,
   input logic [CW-1:0]  pix_per_word,
   input logic [ALW-1:0] alpha_pop_m1,
   input logic           out_valid,
   input logic           out_ready,
   input logic [BW-1:0]  out_word
);
   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word));

   p_ppw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pix_per_word) == LANES || int'(pix_per_word) == LANES / 2);

   p_alpha_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(alpha_pop_m1) < int'(pix_per_word));

   p_opaque_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_ready && res_fmt == 3'd2) |-> out_word[7:0] == 8'hFF);

   p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_ready && res_fmt[2:1] == 2'b00 && pix_avail == CW'(1))
      |-> out_word[BW-1:16] == '0);
endmodule

bind alpha_blend_dp ab_chk #(.BUS_BYTES(BUS_BYTES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .res_fmt      (res_fmt),
   .pix_avail    (pix_avail),
   .pix_per_word (pix_per_word),
   .alpha_pop_m1 (alpha_pop_m1),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_word     (out_word)
);

// File: tb/alpha_blend_dp_bench.sv
`timescale 1ns/1ps
module alpha_blend_dp_bench;
   localparam int BB  = 4;
   localparam int LN  = BB / 2;
   localparam int BW  = 8 * BB;
   localparam int AW  = 8 * LN;
   localparam int CW  = $clog2(LN + 1);
   localparam int SZW = $clog2(BB);
   localparam int ALW = $clog2(LN);

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, out_ready = 1'b0;
   logic [BW-1:0] fg_word = '0, bg_word = '0;
   logic [AW-1:0] alpha_word = '0;
   logic [2:0] fg_fmt = '0, bg_fmt = '0, res_fmt = '0;
   logic [CW-1:0] pix_avail = CW'(1);
   logic in_ready, out_valid;
   logic [CW-1:0] pix_per_word;
   logic [SZW-1:0] fg_pop_m1, bg_pop_m1, res_push_m1;
   logic [ALW-1:0] alpha_pop_m1;
   logic [BW-1:0] out_word;

   int n_chk = 0, n_fail = 0;
   logic [BW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   alpha_blend_dp #(.BUS_BYTES(BB)) u_alpha_blend_dp (.*);

   task automatic chk(input bit ok, input string what, input longint act_v, input longint exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act_v, exp_v);
      end
   endtask

   function automatic bit w16(input int f);
      return f < 2;
   endfunction

   // R4 R5: component extraction, widened to 8 bits
   function automatic void dec(input int f, input logic [BW-1:0] w, input int i,
                               output int r, output int g, output int b);
      logic [15:0] h;
      logic [31:0] x;
      h = 16'(w >> (16 * i));
      x = 32'(w >> (32 * i));
      case (f)
         0: begin r = int'(h[15:11]) * 8; g = int'(h[10:5]) * 4; b = int'(h[4:0]) * 8; end
         1: begin b = int'(h[15:11]) * 8; g = int'(h[10:5]) * 4; r = int'(h[4:0]) * 8; end
         2: begin r = x[31:24]; g = x[23:16]; b = x[15:8]; end
         3: begin b = x[31:24]; g = x[23:16]; r = x[15:8]; end
         4: begin r = x[23:16]; g = x[15:8];  b = x[7:0];  end
         default: begin b = x[23:16]; g = x[15:8]; r = x[7:0]; end
      endcase
   endfunction

   function automatic int ppw_of(input int ff, input int bf, input int rf);
      return (w16(ff) && w16(bf) && w16(rf)) ? LN : LN / 2;
   endfunction

   function automatic logic [BW-1:0] model(input int ff, input int bf, input int rf,
                                           input int avail, input logic [BW-1:0] fw,
                                           input logic [BW-1:0] bw, input logic [AW-1:0] aw);
      logic [BW-1:0] o;
      int act, fr, fgc, fb, br, bgc, bb, a, r, g, b;
      longint px;
      o = '0;
      act = avail < ppw_of(ff, bf, rf) ? avail : ppw_of(ff, bf, rf);
      for (int i = 0; i < act; i++) begin
         dec(ff, fw, i, fr, fgc, fb);
         dec(bf, bw, i, br, bgc, bb);
         a = int'(aw[8*i +: 8]);
         r = (fr * a + br * (255 - a)) / 256;
         g = (fgc * a + bgc * (255 - a)) / 256;
         b = (fb * a + bb * (255 - a)) / 256;
         case (rf)
            0: px = (r / 8) * 2048 + (g / 4) * 32 + b / 8;
            1: px = (b / 8) * 2048 + (g / 4) * 32 + r / 8;
            2: px = (longint'(r) << 24) | (g << 16) | (b << 8) | 255;
            3: px = (longint'(b) << 24) | (g << 16) | (r << 8) | 255;
            4: px = (longint'(255) << 24) | (r << 16) | (g << 8) | b;
            default: px = (longint'(255) << 24) | (b << 16) | (g << 8) | r;
         endcase
         o = o | (BW'(px) << (w16(rf) ? 16 * i : 32 * i));
      end
      return o;
   endfunction

   task automatic check_out();
      if (out_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R10 unexpected out_valid", 1, 0);
         else chk(out_word == exp_q[0], "R4 R5 R6 R7 R8 R9 out_word",
                  longint'(out_word), longint'(exp_q[0]));
      end
   endtask

   task automatic book(input int ff, input int bf, input int rf, input int avail,
                       output bit acc);
      int ppw, act, fwd, bwd, rwd;
      chk(in_ready == (!out_valid || out_ready), "R10 in_ready", in_ready, !out_valid || out_ready);
      acc = 1'b0;
      if (in_valid) begin
         ppw = ppw_of(ff, bf, rf);
         act = avail < ppw ? avail : ppw;
         fwd = w16(ff) ? 2 : 4; bwd = w16(bf) ? 2 : 4; rwd = w16(rf) ? 2 : 4;
         chk(int'(pix_per_word) == ppw, "R2 pix_per_word", pix_per_word, ppw);
         chk(int'(fg_pop_m1) == act * fwd - 1, "R3 fg_pop_m1", fg_pop_m1, act * fwd - 1);
         chk(int'(bg_pop_m1) == act * bwd - 1, "R3 bg_pop_m1", bg_pop_m1, act * bwd - 1);
         chk(int'(alpha_pop_m1) == act - 1, "R3 alpha_pop_m1", alpha_pop_m1, act - 1);
         chk(int'(res_push_m1) == act * rwd - 1, "R3 res_push_m1", res_push_m1, act * rwd - 1);
      end
      if (out_valid && out_ready && exp_q.size() > 0) void'(exp_q.pop_front());
      if (in_valid && in_ready) begin
         exp_q.push_back(model(ff, bf, rf, avail, fg_word, bg_word, alpha_word));
         acc = 1'b1;
      end
   endtask

   task automatic send(input int ff, input int bf, input int rf, input int avail,
                       input logic [BW-1:0] fw, input logic [BW-1:0] bw, input logic [AW-1:0] aw);
      bit acc;
      acc = 1'b0;
      @(negedge clk);
      check_out();
      in_valid = 1'b1; fg_word = fw; bg_word = bw; alpha_word = aw;
      fg_fmt = 3'(ff); bg_fmt = 3'(bf); res_fmt = 3'(rf); pix_avail = CW'(avail);
      out_ready = ($urandom % 4) != 0;
      #1 book(ff, bf, rf, avail, acc);
      while (!acc) begin
         @(negedge clk);
         check_out();
         out_ready = ($urandom % 4) != 0;
         #1 book(ff, bf, rf, avail, acc);
      end
   endtask

   task automatic drain();
      bit acc;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check_out();
         in_valid = 1'b0; out_ready = 1'b1;
         #1 book(0, 0, 0, 1, acc);
      end
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [AW-1:0] aw;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && out_word == '0, "R1 state after reset", out_word, 0);

      // R5: worked conversion from code 2 into code 0, alpha 255
      send(2, 2, 0, LN, 32'h8B4513FF, 32'h12345678, AW'(16'hFFFF));
      drain();

      for (int ff = 0; ff < 6; ff++)
         for (int bf = 0; bf < 6; bf++)
            for (int rf = 0; rf < 6; rf++)
               for (int k = 0; k < 3; k++) begin
                  aw = (k == 0) ? '0 : (k == 1) ? '1 : AW'($urandom);
                  send(ff, bf, rf, LN, BW'($urandom), BW'($urandom), aw);
                  if (ppw_of(ff, bf, rf) == LN)   // R9: short final word
                     send(ff, bf, rf, 1, BW'($urandom), BW'($urandom), AW'($urandom));
               end
      drain();
      chk(exp_q.size() == 0, "R10 all words delivered", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule